// File: doc/BRIEF.md
# Dual-Channel Power Switch Sequencer

This block is the digital control core for two external power switches. Each channel has an active-low enable input, an on/off control input, and comparator inputs for overvoltage, short circuit and power-good feedback. The block keeps an on-bit per channel and raises a gate-on request per channel. A fixed-length startup timer models each channel's turn-on sequence. When the timer expires, the channel is marked as started and its power-good output becomes meaningful.

A strap input picks the operating mode. In ganged mode both channels start together, and any turn-off cause on either channel stops both. In independent mode each channel runs on its own, and only one channel may be in its turn-on sequence at a time. Faults are logged per channel in sticky registers and drive an open-drain style alert output through per-bit enable masks. A small write port can set the on-bits, load the alert masks and clear fault bits by writing ones.

Top module: `dual_switch_seq`

## Requirements
- R1: After reset, both on-bits stay 0 for PWRUP_CYC clock edges. At edge number PWRUP_CYC each on-bit loads the level of its on input.
- R2: After power-up, a rising edge on a channel's on input sets its on-bit. A falling edge clears the on-bit and also clears all of that channel's fault bits.
- R3: While a channel's active-low enable is high, its gate stays off. A rising enable edge clears the on-bit. A falling enable edge reloads the on-bit from the on input and clears the channel's faults. Every enable edge sets fault bit 3 (enable changed).
- R4: A high overvoltage input sets fault bit 0 and clears the on-bit on the next edge. It also forces the gate off in the same cycle, without waiting for a clock edge.
- R5: A short-circuit input that is high while the gate is on sets fault bit 1 and clears the on-bit.
- R6: Fault bit 2 (power bad) is set only when three conditions hold together: power-good feedback is low, the startup has completed, and the gate is on. Power bad does not turn the channel off. pwr_good is high only when the channel has started and its feedback is high.
- R7: In independent mode, a fault or turn-off on one channel leaves the other channel's on-bit, gate and fault bits unchanged.
- R8: In independent mode, at most one channel is ramping at any time. Channel 0 wins when both are ready together. A waiting channel starts ramping one cycle after the other channel's startup completes.
- R9: In ganged mode, both gates turn on together and only once both channels are ready (on-bit set and enable low). Any turn-off cause on either channel clears both on-bits.
- R10: A gate that turns on ramps for exactly STARTUP_CYC edges. start_done then goes high and stays high while the gate is on.
- R11: A write to address 0 loads the on-bits from wr_data[1:0], with bit 0 for channel 0. A write to address 1 loads the alert masks, with wr_data[3:0] for channel 0 faults and wr_data[7:4] for channel 1 faults. A write to address 2 clears every fault bit whose data bit is 1, using the same bit layout.
- R12: Fault bits are sticky. When a fault is set and cleared in the same cycle, it ends up set.
- R13: alert_n is low exactly when some logged fault bit has its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_indep | input | 1 | Strap: 1 = independent channels, 0 = ganged |
| en_n | input | 2 | Per-channel enable, active low |
| on_in | input | 2 | Per-channel on/off control |
| ov_in | input | 2 | Overvoltage comparator, 1 = over |
| sc_in | input | 2 | Short-circuit comparator, 1 = short |
| pg_in | input | 2 | Feedback comparator, 1 = output good |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 on-bits, 1 masks, 2 fault clear |
| wr_data | input | 8 | Register write data |
| gate_on | output | 2 | Gate-on request per channel |
| on_bit | output | 2 | On-bit per channel |
| start_done | output | 2 | Startup completed per channel |
| pwr_good | output | 2 | Power-good indication per channel |
| fault_ch0 | output | 4 | Channel 0 fault log: bit0 OV, bit1 short, bit2 power bad, bit3 enable change |
| fault_ch1 | output | 4 | Channel 1 fault log, same layout |
| alert_n | output | 1 | Alert, 0 = pulled low |

## Verification
On-bit, fault and alert results appear one edge after the stimulus edge that causes them, because alert_n is decoded combinationally from the registered faults. The gate request follows the on-bit by one more edge. start_done follows STARTUP_CYC edges after that, and the overvoltage gate cut is visible in the same cycle. The bench drives inputs on falling edges and counts rising edges explicitly before sampling at the next falling edge. The ramp-order and power-up checks land exactly one edge before and at the edge where the output is due. Settled-state checks from the vector table wait well beyond the longest such chain.

// File: rtl/dss_pkg.sv
// Package: shared constants and types for the dual switch sequencer.
// Assumes exactly two channels and four fault causes per channel.
package dss_pkg;
    localparam int NCH  = 2;
    localparam int NFLT = 4;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RAMP = 2'd1,
        CH_UP   = 2'd2
    } ch_state_t;

    localparam logic [1:0] A_ONBIT = 2'd0;
    localparam logic [1:0] A_MASK  = 2'd1;
    localparam logic [1:0] A_CLEAR = 2'd2;
endpackage

// File: rtl/dss_powerup.sv
// Power-up delay: counts CYC edges after reset, pulses fire_o on the
// last one and then holds done_o high. Assumes CYC >= 1.
module dss_powerup #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic fire_o,
    output logic done_o
);
    localparam int W = $clog2(CYC + 1);

    logic [W-1:0] cnt;

    assign fire_o = !done_o && (cnt == W'(CYC - 1));

    // Advance the delay counter until the delay has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            if (fire_o) done_o <= 1'b1;
            else        cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dss_fault_log.sv
// Sticky fault log for one channel: set bits win over clear bits.
// Assumes set_i and clr_i are single-cycle qualified strobes/levels.
module dss_fault_log #(
    parameter int NFLT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] set_i,
    input  logic [NFLT-1:0] clr_i,
    output logic [NFLT-1:0] q_o
);
    // Hold, clear and set fault bits, set taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_i) | set_i;
    end

    // R12: a set request is always visible on the next cycle
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R12: a logged bit stays until a clear request reaches it
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(q_o & ~clr_i)) |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));
endmodule

// File: rtl/dss_chan_fsm.sv
// Turn-on sequencer for one channel: IDLE -> RAMP for STARTUP_CYC
// edges -> UP. Dropping keep_i returns to IDLE from any state.
// Assumes go_i is only raised when keep_i is also high.
module dss_chan_fsm
    import dss_pkg::*;
#(
    parameter int STARTUP_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic keep_i,
    output logic active_o,
    output logic ramp_o,
    output logic done_o
);
    localparam int CW = $clog2(STARTUP_CYC + 1);

    ch_state_t     st;
    logic [CW-1:0] cnt;

    assign active_o = (st != CH_IDLE);
    assign ramp_o   = (st == CH_RAMP);
    assign done_o   = (st == CH_UP);

    // Step the channel through its startup sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                CH_IDLE: if (go_i) begin
                    st  <= CH_RAMP;
                    cnt <= '0;
                end
                CH_RAMP: begin
                    if (!keep_i)                         st  <= CH_IDLE;
                    else if (cnt == CW'(STARTUP_CYC - 1)) st  <= CH_UP;
                    else                                 cnt <= cnt + 1'b1;
                end
                CH_UP:   if (!keep_i) st <= CH_IDLE;
                default: st <= CH_IDLE;
            endcase
        end
    end

    // R10: startup completes only after a full ramp
    p_done_after_ramp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(ramp_o) && ($past(cnt) == CW'(STARTUP_CYC - 1))));
endmodule

// File: rtl/dual_switch_seq.sv
// Top: dual power-switch sequencer. Detects edges on enable and on
// inputs, keeps on-bits, logs faults, sequences gate turn-on in ganged
// or independent mode and raises a masked alert.
// Assumes all inputs are already synchronous to clk and that the
// mode strap only changes while rst_n is low.
module dual_switch_seq
    import dss_pkg::*;
#(
    parameter int PWRUP_CYC   = 10_000_000,
    parameter int STARTUP_CYC = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_indep,
    input  logic [1:0]       en_n,
    input  logic [1:0]       on_in,
    input  logic [1:0]       ov_in,
    input  logic [1:0]       sc_in,
    input  logic [1:0]       pg_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output logic [1:0]       gate_on,
    output logic [1:0]       on_bit,
    output logic [1:0]       start_done,
    output logic [1:0]       pwr_good,
    output logic [3:0]       fault_ch0,
    output logic [3:0]       fault_ch1,
    output logic             alert_n
);
    localparam int DW = NCH * NFLT;

    logic [NCH-1:0]            on_q, en_q;
    logic [NCH-1:0]            on_rise, on_fall, en_rise, en_fall;
    logic [NCH-1:0]            off_evt, off_all, ready, keep, keep_eff, go;
    logic [NCH-1:0]            active, ramping, done_v, ov_cut, on_nxt;
    logic [NCH-1:0][NFLT-1:0]  set_v, clr_v, flt;
    logic [DW-1:0]             mask_q;
    logic                      pu_fire, pu_done;
    logic                      wr_on, wr_mask, wr_clr;

    assign wr_on   = wr_en && (wr_addr == A_ONBIT);
    assign wr_mask = wr_en && (wr_addr == A_MASK);
    assign wr_clr  = wr_en && (wr_addr == A_CLEAR);

    // Remember previous input levels for edge detection (loaded in reset
    // so that reset release never looks like an edge).
    always_ff @(posedge clk) begin
        on_q <= on_in;
        en_q <= en_n;
    end

    assign on_rise = on_in & ~on_q;
    assign on_fall = ~on_in & on_q;
    assign en_rise = en_n & ~en_q;
    assign en_fall = ~en_n & en_q;

    dss_powerup #(.CYC(PWRUP_CYC)) u_pwrup (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_o (pu_fire),
        .done_o (pu_done)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // fault layout: [3] enable change, [2] power bad, [1] short, [0] OV
        assign set_v[i] = {en_rise[i] | en_fall[i],
                           ~pg_in[i] & done_v[i] & gate_on[i],
                           sc_in[i] & gate_on[i],
                           ov_in[i]};
        assign clr_v[i] = ({NFLT{wr_clr}} & wr_data[i*NFLT +: NFLT])
                        | {NFLT{on_fall[i] | en_fall[i]}};
        assign off_evt[i] = ov_in[i] | set_v[i][1] | on_fall[i] | en_rise[i];

        dss_fault_log #(.NFLT(NFLT)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (flt[i])
        );

        dss_chan_fsm #(.STARTUP_CYC(STARTUP_CYC)) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_i     (go[i]),
            .keep_i   (keep_eff[i]),
            .active_o (active[i]),
            .ramp_o   (ramping[i]),
            .done_o   (done_v[i])
        );

        // R3: an enable held high keeps the gate off
        p_en_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (en_n[i] && $past(en_n[i])) |-> !gate_on[i]);

        // R4: overvoltage clears the on-bit on the next edge
        p_ov_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ov_in[i] |=> !on_bit[i]);
    end

    // Turn-off causes reach both channels in ganged mode.
    assign off_all = mode_indep ? off_evt : {NCH{|off_evt}};
    assign ov_cut  = mode_indep ? ov_in   : {NCH{|ov_in}};

    // Work out the next on-bits; every turn-off cause overrides a turn-on.
    always_comb begin
        on_nxt = on_bit;
        if (pu_fire) begin
            on_nxt = on_in;
        end else if (pu_done) begin
            if (wr_on) on_nxt = wr_data[NCH-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (on_rise[i]) on_nxt[i] = 1'b1;
                if (en_fall[i]) on_nxt[i] = on_in[i];
            end
        end
        on_nxt = on_nxt & ~off_all;
    end

    // Hold the on-bits.
    always_ff @(posedge clk) begin
        if (!rst_n) on_bit <= '0;
        else        on_bit <= on_nxt;
    end

    assign ready = on_bit & ~en_n;
    assign keep  = ready & ~off_all;

    // Grant ramps: together in ganged mode, one at a time otherwise.
    always_comb begin
        if (!mode_indep) begin
            go       = {NCH{(&keep) && !(|active)}};
            keep_eff = {NCH{&keep}};
        end else begin
            go[0]    = keep[0] & ~active[0] & ~ramping[1];
            go[1]    = keep[1] & ~active[1] & ~ramping[0] & ~go[0];
            keep_eff = keep;
        end
    end

    // Load the alert masks from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wr_data;
    end

    assign gate_on    = active & ~ov_cut;
    assign start_done = done_v;
    assign pwr_good   = done_v & pg_in;
    assign fault_ch0  = flt[0];
    assign fault_ch1  = flt[1];
    assign alert_n    = ~|(flt & mask_q);

    // R1: no channel may be on before the power-up delay ends
    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pu_done |-> (on_bit == '0));

    // R7: overvoltage on channel 0 leaves channel 1's on-bit alone
    p_iso_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_indep && ov_in[0] && !off_evt[1] && !wr_on && !pu_fire && on_bit[1])
        |=> on_bit[1]);

    // R8: never two channels ramping at once in independent mode
    p_serial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_indep |-> !(ramping[0] && ramping[1]));

    // R9: ganged gates always move together
    p_gang_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_indep |-> (gate_on[0] == gate_on[1]));
endmodule

// File: tb/test_dual_switch_seq.sv
`timescale 1ns/1ps
module test_dual_switch_seq;
    localparam int PU = 20;
    localparam int SU = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode = 1'b1;
    logic [1:0] en_n = 2'b00, on_in = 2'b00, ov = 2'b00, sc = 2'b00, pg = 2'b11;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'b00;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] gate_on, on_bit, start_done, pwr_good;
    logic [3:0] f0, f1;
    logic       alert_n;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    dual_switch_seq #(.PWRUP_CYC(PU), .STARTUP_CYC(SU)) i_dual_switch_seq (
        .clk(clk), .rst_n(rst_n), .mode_indep(mode), .en_n(en_n), .on_in(on_in),
        .ov_in(ov), .sc_in(sc), .pg_in(pg), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .gate_on(gate_on), .on_bit(on_bit),
        .start_done(start_done), .pwr_good(pwr_good), .fault_ch0(f0),
        .fault_ch1(f1), .alert_n(alert_n)
    );

    typedef struct packed {
        logic [1:0] en_v;
        logic [1:0] on_v;
        logic [1:0] ov_v;
        logic [1:0] x_gate;
        logic [1:0] x_on;
        logic [1:0] x_done;
        logic [3:0] x_f0;
        logic [3:0] x_f1;
    } vec_t;

    // Independent mode, settled results. v0,v1: R2 turn-on; v2,v3: R4 and
    // R7 (channel 1 OV, channel 0 unaffected); v4: R2 fault clear on fall;
    // v5: R2 restart; v6: R3 enable rise; v7: R3 enable fall reload.
    localparam vec_t VT [0:7] = '{
        '{2'b00, 2'b01, 2'b00, 2'b01, 2'b01, 2'b01, 4'h0, 4'h0},
        '{2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 4'h0, 4'h0},
        '{2'b00, 2'b11, 2'b10, 2'b01, 2'b01, 2'b01, 4'h0, 4'h1},
        '{2'b00, 2'b11, 2'b00, 2'b01, 2'b01, 2'b01, 4'h0, 4'h1},
        '{2'b00, 2'b01, 2'b00, 2'b01, 2'b01, 2'b01, 4'h0, 4'h0},
        '{2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 4'h0, 4'h0},
        '{2'b01, 2'b11, 2'b00, 2'b10, 2'b10, 2'b10, 4'h8, 4'h0},
        '{2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 4'h8, 4'h0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold_reset(input logic m, input logic [1:0] on_v);
        rst_n = 1'b0; mode = m; on_in = on_v; en_n = 2'b00; ov = 2'b00;
        sc = 2'b00; pg = 2'b11; wr_en = 1'b0;
        step(3);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // Reset state (R1): everything off and quiet
        hold_reset(1'b1, 2'b01);
        chk("R1 reset gate", {6'b0, gate_on}, 8'h00);
        chk("R1 reset on-bit", {6'b0, on_bit}, 8'h00);
        chk("R13 reset alert", {7'b0, alert_n}, 8'h01);
        chk("R12 reset faults", {f1, f0}, 8'h00);

        // R1: power-up delay, then load from on input level
        rst_n = 1'b1;
        step(PU - 1);
        chk("R1 before delay", {6'b0, on_bit}, 8'h00);
        step(1);
        chk("R1 at delay", {6'b0, on_bit}, 8'h01);
        // R11: on-bit write
        wr(2'd0, 8'h03);
        chk("R11 on-bit write", {6'b0, on_bit}, 8'h03);

        // Vector table, independent mode
        hold_reset(1'b1, 2'b00);
        rst_n = 1'b1;
        step(PU + 5);
        for (int v = 0; v < 8; v++) begin
            en_n = VT[v].en_v; on_in = VT[v].on_v; ov = VT[v].ov_v;
            step(SU + 4);
            chk($sformatf("table %0d gate", v), {6'b0, gate_on}, {6'b0, VT[v].x_gate});
            chk($sformatf("table %0d on-bit", v), {6'b0, on_bit}, {6'b0, VT[v].x_on});
            chk($sformatf("table %0d done", v), {6'b0, start_done}, {6'b0, VT[v].x_done});
            chk($sformatf("table %0d faults", v), {f1, f0}, {VT[v].x_f1, VT[v].x_f0});
        end
        ov = 2'b00;
        on_in = 2'b00;
        step(SU + 4);
        chk("R2 both off", {on_bit, gate_on}, 8'h00);

        // R8/R10: serialized turn-on in independent mode
        on_in = 2'b11;
        step(1);
        chk("R8 on-bits set", {gate_on, on_bit}, {2'b00, 2'b11});
        step(1);
        chk("R8 ch0 first", {6'b0, gate_on}, 8'h01);
        step(SU);
        chk("R10 ch0 done", {start_done, gate_on}, {2'b01, 2'b01});
        step(1);
        chk("R8 ch1 granted", {6'b0, gate_on}, 8'h03);
        step(SU - 1);
        chk("R10 ch1 not yet", {6'b0, start_done}, 8'h01);
        step(1);
        chk("R10 ch1 done", {6'b0, start_done}, 8'h03);

        // R5/R13/R7: short on channel 0 with all masks on
        wr(2'd1, 8'hFF);
        sc = 2'b01;
        step(1);
        sc = 2'b00;
        step(2);
        chk("R5 short logged", {f1, f0}, 8'h02);
        chk("R5 on-bit cleared", {on_bit, gate_on}, {2'b10, 2'b10});
        chk("R13 alert low", {7'b0, alert_n}, 8'h00);
        // R11: write-one-to-clear
        wr(2'd2, 8'h02);
        chk("R11 clear", {f1, f0}, 8'h00);
        chk("R13 alert released", {7'b0, alert_n}, 8'h01);
        // R12: set beats clear in the same cycle; R13 masked cause
        wr(2'd1, 8'hF0);
        ov = 2'b01;
        wr(2'd2, 8'h01);
        chk("R12 set wins", {f1, f0}, 8'h01);
        chk("R13 masked", {7'b0, alert_n}, 8'h01);
        ov = 2'b00;
        wr(2'd2, 8'h01);
        chk("R11 clear ov", {f1, f0}, 8'h00);

        // R6: power bad only where started and gated, no shutdown
        pg = 2'b00;
        step(3);
        chk("R6 power bad", {f1, f0}, 8'h40);
        chk("R6 no shutdown", {6'b0, gate_on}, 8'h02);
        chk("R6 pwr_good low", {6'b0, pwr_good}, 8'h00);
        chk("R13 alert on pbad", {7'b0, alert_n}, 8'h00);
        pg = 2'b11;
        wr(2'd2, 8'hF0);
        chk("R6 pwr_good", {6'b0, pwr_good}, 8'h02);
        chk("R13 cleared", {7'b0, alert_n}, 8'h01);

        // R9: ganged mode
        hold_reset(1'b0, 2'b00);
        rst_n = 1'b1;
        step(PU + 5);
        on_in = 2'b01;
        step(SU + 4);
        chk("R9 one ready waits", {on_bit, gate_on}, {2'b01, 2'b00});
        on_in = 2'b11;
        step(1);
        chk("R9 both set", {on_bit, gate_on}, {2'b11, 2'b00});
        step(1);
        chk("R9 together", {6'b0, gate_on}, 8'h03);
        step(SU - 1);
        chk("R10 ganged not yet", {6'b0, start_done}, 8'h00);
        step(1);
        chk("R10 ganged done", {6'b0, start_done}, 8'h03);
        ov = 2'b10;
        #1;
        chk("R4 immediate cut", {6'b0, gate_on}, 8'h00);
        step(1);
        chk("R9 both off", {6'b0, on_bit}, 8'h00);
        ov = 2'b00;
        step(5);
        chk("R9 stays off", {on_bit, gate_on}, 8'h00);
        chk("R4 ov logged", {f1, f0}, 8'h10);

        finish_run();
    end
endmodule